// File: doc/BRIEF.md
# Pipelined Fixed-Weight Perceptron Classifier

This block runs inference for a small feedforward neural network with constant weights. It has four signed 16-bit input features, four hidden neurons and three output neurons. The input layer does no arithmetic: each feature goes straight to every hidden neuron. Every neuron has two register stages. The first stage holds the weighted products and the second holds the activated result. Because both layers are built this way, the datapath is four stages deep. It accepts one input vector per clock and can hold four vectors in flight at once.

All values use a signed fixed-point format with FRAC fractional bits, where 1.0 is 2^FRAC. The sigmoid is replaced by a clamped straight line. Weights and biases are elaboration-time parameters that were trained offline. A valid bit travels with each vector. A combinational argmax over the registered output scores gives the winning class index.

Top module: `mlp_classifier`

## Requirements
- R1: `out_valid_o` rises exactly four clock cycles after each cycle in which `in_valid_i` is high. Back-to-back inputs give back-to-back results, so the throughput is one vector per clock.
- R2: While `rst_ni` is low, `out_valid_o` is 0, and every vector already in flight is discarded. After release, no result appears until a new vector is accepted.
- R3: Hidden neuron j outputs act(((Σ_i x_i·wh_{j,i}) >>> FRAC) + bh_j). The products and the sum are exact signed values, and >>> is an arithmetic (floor) shift.
- R4: Output neuron k applies the same formula to the four hidden outputs, using weights wo_{k,i} and bias bo_k.
- R5: act(p) = clamp((p >>> 2) + 2^(FRAC−1), 0, 2^FRAC), so every neuron output lies in [0, 2^FRAC].
- R6: `out_class_o` is the index of the largest of the three output scores. If scores are equal, the lowest index wins.
- R7: A cycle with `in_valid_i` low produces no result, and the data present in that cycle does not affect any result.
- R8: Feature i occupies `in_feat_i[16i+15:16i]`. Score k occupies `out_score_o[16k+15:16k]`. Weight (n,i) occupies the weight parameter bits [(4n+i)·16 +: 16], and bias n occupies [16n +: 16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by all pipeline registers |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the valid bits |
| in_valid_i | input | 1 | Input vector present this cycle |
| in_feat_i | input | 64 | Four signed 16-bit features |
| out_valid_o | output | 1 | Result present this cycle |
| out_score_o | output | 48 | Three 16-bit output scores |
| out_class_o | output | 2 | Index of the highest score, lowest on ties |

## Verification
Each accepted vector produces its scores and its class index together, four rising edges after the edge that accepted it. The class index adds no delay, because it is decoded from the score registers. The bench drives inputs and samples outputs on the falling edge. It keeps a four-entry history of the valid bits it has driven, so each sample is compared with the vector sent four cycles earlier, and expected values leave a queue in arrival order. Bubbles, a reset in mid-flight and a near-exhaustive sweep of extreme feature values all use this same alignment.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  // width used for the pre-activation value; wide enough for 2*W + log2(N_IN) + 1
  localparam int unsigned PRE_W = 48;
endpackage

// File: rtl/mlp_neuron.sv
module mlp_neuron
  import mlp_pkg::*;
#(
  parameter int unsigned           N_IN = 4,
  parameter int unsigned           W    = 16,
  parameter int unsigned           FRAC = 8,
  parameter logic [N_IN*W-1:0]     WGT  = '0,
  parameter logic [W-1:0]          BIAS = '0
) (
  input  logic              clk_i,
  input  logic [N_IN*W-1:0] x_i,
  output logic [W-1:0]      y_o
);
  localparam int unsigned PROD_W = 2 * W;
  localparam int unsigned SUM_W  = PROD_W + $clog2(N_IN) + 1;
  localparam logic signed [PRE_W-1:0] ONE  = PRE_W'(1) <<< FRAC;
  localparam logic signed [PRE_W-1:0] HALF = ONE >>> 1;

  function automatic logic [W-1:0] pwl(input logic signed [PRE_W-1:0] p);
    logic signed [PRE_W-1:0] t;
    t = (p >>> 2) + HALF;
    if (t < 0)   return '0;
    if (t > ONE) return ONE[W-1:0];
    return t[W-1:0];
  endfunction

  // stage 1: products
  logic signed [PROD_W-1:0] prod_q [N_IN];
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N_IN; i++) begin
      prod_q[i] <= PROD_W'($signed(x_i[i*W +: W])) * PROD_W'($signed(WGT[i*W +: W]));
    end
  end

  // stage 2: sum, bias, activation
  logic signed [SUM_W-1:0] sum;
  logic signed [PRE_W-1:0] pre;
  always_comb begin
    sum = '0;
    for (int i = 0; i < N_IN; i++) sum = sum + SUM_W'(prod_q[i]);
    pre = (PRE_W'(sum) >>> FRAC) + PRE_W'($signed(BIAS));
  end

  logic [W-1:0] y_q;
  always_ff @(posedge clk_i) y_q <= pwl(pre);
  assign y_o = y_q;
endmodule

// File: rtl/mlp_layer.sv
module mlp_layer #(
  parameter int unsigned             N_IN  = 4,
  parameter int unsigned             N_OUT = 4,
  parameter int unsigned             W     = 16,
  parameter int unsigned             FRAC  = 8,
  parameter logic [N_OUT*N_IN*W-1:0] WGT   = '0,
  parameter logic [N_OUT*W-1:0]      BIAS  = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [N_IN*W-1:0]  x_i,
  output logic               valid_o,
  output logic [N_OUT*W-1:0] y_o
);
  localparam logic [W-1:0] ONE_W = W'(1) << FRAC;

  logic [1:0] vld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[0], valid_i};
  end
  assign valid_o = vld_q[1];

  for (genvar n = 0; n < N_OUT; n++) begin : g_neuron
    mlp_neuron #(
      .N_IN (N_IN),
      .W    (W),
      .FRAC (FRAC),
      .WGT  (WGT[n*N_IN*W +: N_IN*W]),
      .BIAS (BIAS[n*W +: W])
    ) u_neuron (
      .clk_i (clk_i),
      .x_i   (x_i),
      .y_o   (y_o[n*W +: W])
    );

    a_r5_act_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (y_o[n*W +: W] <= ONE_W));
  end

  a_r1_two_stage_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  a_r7_no_phantom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
endmodule

// File: rtl/mlp_argmax.sv
module mlp_argmax #(
  parameter int unsigned N     = 3,
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N*W-1:0]   scores_i,
  output logic [IDX_W-1:0] idx_o
);
  logic signed [W-1:0] best;
  always_comb begin
    idx_o = '0;
    best  = $signed(scores_i[W-1:0]);
    for (int k = 1; k < N; k++) begin
      // strict compare keeps the lowest index on ties
      if ($signed(scores_i[k*W +: W]) > best) begin
        best  = $signed(scores_i[k*W +: W]);
        idx_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/mlp_classifier.sv
module mlp_classifier #(
  parameter int unsigned W     = 16,
  parameter int unsigned FRAC  = 8,
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_HID = 4,
  parameter int unsigned N_OUT = 3,
  parameter logic [N_HID*N_IN*W-1:0] HID_WGT = {
    16'hFFC0, 16'h0080, 16'hFF00, 16'h0000,
    16'h0200, 16'h0020, 16'h0040, 16'hFF80,
    16'h0000, 16'h0100, 16'h0000, 16'h0100,
    16'h0000, 16'h0000, 16'h0100, 16'h0100},
  parameter logic [N_HID*W-1:0] HID_BIAS = {16'hFF00, 16'h0080, 16'h0000, 16'h0000},
  parameter logic [N_OUT*N_HID*W-1:0] OUT_WGT = {
    16'h0100, 16'h0100, 16'hFF00, 16'hFF00,
    16'h0000, 16'h0000, 16'h0100, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0100},
  parameter logic [N_OUT*W-1:0] OUT_BIAS = {16'h0080, 16'h0000, 16'h0000},
  localparam int unsigned CLS_W = $clog2(N_OUT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [N_IN*W-1:0]  in_feat_i,
  output logic               out_valid_o,
  output logic [N_OUT*W-1:0] out_score_o,
  output logic [CLS_W-1:0]   out_class_o
);
  logic               hid_valid;
  logic [N_HID*W-1:0] hid_y;

  mlp_layer #(
    .N_IN (N_IN), .N_OUT (N_HID), .W (W), .FRAC (FRAC),
    .WGT  (HID_WGT), .BIAS (HID_BIAS)
  ) u_hidden (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .x_i     (in_feat_i),
    .valid_o (hid_valid),
    .y_o     (hid_y)
  );

  mlp_layer #(
    .N_IN (N_HID), .N_OUT (N_OUT), .W (W), .FRAC (FRAC),
    .WGT  (OUT_WGT), .BIAS (OUT_BIAS)
  ) u_output (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (hid_valid),
    .x_i     (hid_y),
    .valid_o (out_valid_o),
    .y_o     (out_score_o)
  );

  mlp_argmax #(.N (N_OUT), .W (W), .IDX_W (CLS_W)) u_argmax (
    .scores_i (out_score_o),
    .idx_o    (out_class_o)
  );

  a_r1_latency_four: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##4 out_valid_o);
  a_r6_class_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (32'(out_class_o) < N_OUT));

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    a_r6_none_larger: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> ($signed(out_score_o[k*W +: W]) <= $signed(out_score_o[out_class_o*W +: W])));
    a_r6_lowest_on_tie: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && (k < 32'(out_class_o))) |->
        ($signed(out_score_o[k*W +: W]) < $signed(out_score_o[out_class_o*W +: W])));
  end
endmodule

// File: tb/mlp_classifier_bench.sv
`timescale 1ns/1ps
module mlp_classifier_bench;
  localparam logic [255:0] HW = {
    16'hFFC0, 16'h0080, 16'hFF00, 16'h0000,
    16'h0200, 16'h0020, 16'h0040, 16'hFF80,
    16'h0000, 16'h0100, 16'h0000, 16'h0100,
    16'h0000, 16'h0000, 16'h0100, 16'h0100};
  localparam logic [63:0]  HB = {16'hFF00, 16'h0080, 16'h0000, 16'h0000};
  localparam logic [191:0] OW = {
    16'h0100, 16'h0100, 16'hFF00, 16'hFF00,
    16'h0000, 16'h0000, 16'h0100, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0100};
  localparam logic [47:0]  OB = {16'h0080, 16'h0000, 16'h0000};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [63:0] in_feat = '0;
  logic        out_valid;
  logic [47:0] out_score;
  logic [1:0]  out_class;

  always #2.5 clk = ~clk;

  mlp_classifier #(
    .HID_WGT (HW), .HID_BIAS (HB), .OUT_WGT (OW), .OUT_BIAS (OB)
  ) u_mlp_classifier (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_feat_i   (in_feat),
    .out_valid_o (out_valid),
    .out_score_o (out_score),
    .out_class_o (out_class)
  );

  int checks = 0;
  int errors = 0;
  int ties   = 0;
  bit done   = 0;
  logic [3:0]  hist = '0;
  logic [47:0] q_s[$];
  int          q_c[$];

  // R5 activation, R3/R4 neuron arithmetic
  function automatic longint act(longint p);
    longint t;
    t = (p >>> 2) + 128;
    if (t < 0) return 0;
    if (t > 256) return 256;
    return t;
  endfunction

  function automatic longint wsel(logic [255:0] v, int idx);
    return longint'($signed(v[idx*16 +: 16]));
  endfunction

  task automatic model(input logic [63:0] f, output logic [47:0] s, output int c);
    longint x [4];
    longint h [4];
    longint o [3];
    longint acc;
    for (int i = 0; i < 4; i++) x[i] = longint'($signed(f[i*16 +: 16]));
    for (int n = 0; n < 4; n++) begin
      acc = 0;
      for (int i = 0; i < 4; i++) acc += x[i] * wsel(HW, n*4 + i);
      h[n] = act((acc >>> 8) + wsel({192'd0, HB}, n));
    end
    for (int k = 0; k < 3; k++) begin
      acc = 0;
      for (int i = 0; i < 4; i++) acc += h[i] * wsel({64'd0, OW}, k*4 + i);
      o[k] = act((acc >>> 8) + wsel({208'd0, OB}, k));
      s[k*16 +: 16] = o[k][15:0];
    end
    c = 0;
    for (int k = 1; k < 3; k++) if (o[k] > o[c]) c = k;
    for (int k = 0; k < 3; k++) if (k != c && o[k] == o[c]) begin ties++; break; end
  endtask

  task automatic check_out();
    logic [47:0] es;
    int ec;
    checks++;
    if (out_valid !== hist[3]) begin
      errors++;
      $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, hist[3]);
    end
    if (out_valid === 1'b1 && hist[3] && q_s.size() > 0) begin
      es = q_s.pop_front();
      ec = q_c.pop_front();
      checks++;
      if (out_score !== es) begin
        errors++;
        $display("FAIL R3/R4 scores actual=%h expected=%h", out_score, es);
      end
      checks++;
      if (int'(out_class) != ec) begin
        errors++;
        $display("FAIL R6 class actual=%0d expected=%0d", out_class, ec);
      end
    end
  endtask

  task automatic step(input logic v, input logic [63:0] f);
    logic [47:0] s;
    int c;
    @(negedge clk);
    check_out();
    in_valid = v;
    in_feat  = f;
    if (v) begin
      model(f, s, c);
      q_s.push_back(s);
      q_c.push_back(c);
    end
    hist = {hist[2:0], v};
  endtask

  initial begin : main
    logic [15:0] vals [10];
    vals = '{16'h8000, 16'hFE00, 16'hFF00, 16'hFFFF, 16'h0000,
             16'h0001, 16'h00FF, 16'h0100, 16'h03E8, 16'h7FFF};
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 reset out_valid actual=%0b expected=0", out_valid);
    end
    rst_n = 1;

    // R3 R4 R5 R8: near-exhaustive sweep, back-to-back (R1)
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 10; c++)
          for (int d = 0; d < 10; d++)
            step(1'b1, {vals[d], vals[c], vals[b], vals[a]});

    // R7: bubbles carrying garbage data
    for (int k = 0; k < 60; k++)
      step(k % 3 != 0, {16'(k*977), 16'(k*131 - 900), 16'hDEAD ^ 16'(k), 16'(k*4001)});
    repeat (6) step(1'b0, 64'hFFFF_0000_FFFF_0000);

    // R2: reset with vectors in flight
    for (int k = 0; k < 3; k++) step(1'b1, {16'h0100, 16'h0100, 16'h0100, 16'(k*256)});
    @(negedge clk);
    rst_n = 0;
    in_valid = 0;
    hist = '0;
    q_s.delete();
    q_c.delete();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 during reset actual=%0b expected=0", out_valid);
    end
    rst_n = 1;
    repeat (6) step(1'b0, 64'h1234_5678_9ABC_DEF0);
    // pipeline restarts cleanly after reset (R2)
    for (int k = 0; k < 8; k++) step(1'b1, {16'(k*300), 16'hFF00, 16'(k*64), 16'h7FFF});
    repeat (6) step(1'b0, '0);

    checks++;
    if (q_s.size() != 0) begin
      errors++;
      $display("FAIL R1 leftover results actual=%0d expected=0", q_s.size());
    end
    checks++;
    if (ties == 0) begin
      errors++;
      $display("FAIL R6 tie vectors actual=0 expected>0");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule